// File: doc/BRIEF.md
# Shadowed Lane Attribute Configuration Bank

This block stores the 8-bit configuration attributes of one serial lane and serves them over a small attribute port clocked by a dedicated configuration clock. Each writable attribute exists twice. The shadow copy is staged by software-like traffic while the lane runs. The effective copy is what the lane actually uses and what reads return. A write goes to one copy or the other, chosen by a select input. A separate update strobe moves the whole staged set into the effective copy. The move is only carried out while the lane reports that it is in a save state, so that the live configuration never changes mid-burst.

The attribute space holds three kinds of entry. Writable attributes sit at the low addresses. A few read-only capability constants come next, followed by one status attribute. Every other address is unmapped. A controller with three named states sequences the traffic. IDLE accepts accesses. HOLD lasts one cycle after an accepted write. COPY moves the shadow set into the effective set one entry per cycle.

The transitions are as follows. IDLE goes to HOLD on an accepted write. IDLE goes to COPY when an update is requested or pending, the save state is high and no write is accepted in that cycle. HOLD always returns to IDLE. COPY returns to IDLE after the last entry. The active-low ready output is low only in IDLE.

Top module: `attr_bank_top`

## Requirements
- R1: While reset is high and after it is released, writable attribute i (addresses 0 to 15) reads as 8'h20 + 3*i in both copies. The ready output ready_n is 0, nothing is pending and rd_data is 0.
- R2: An enabled read (cfg_en=1, wr_not_rd=0) loads rd_data at the next clock edge. In cycles without an enabled read, rd_data holds its value.
- R3: An accepted write with bank_sel=1 to a writable address updates the effective copy, and a later read returns the written value.
- R4: An accepted write with bank_sel=0 updates only the shadow copy, and reads of that address still return the effective value.
- R5: Writes are accepted only while ready_n is 0. After an accepted write, ready_n is 1 for exactly one cycle. A write presented while ready_n is 1 is ignored.
- R6: When upd_req is high, save_state is 1 and the controller is in IDLE, every writable shadow entry is copied to the effective copy. During the copy, ready_n stays 1 for 16 cycles (one per attribute). After it, every writable address reads its shadow value.
- R7: An update requested while save_state is 0 is held pending and changes nothing. The copy starts in the first IDLE cycle in which save_state is 1.
- R8: Addresses 8'h80 to 8'h83 read as 8'hA0 to 8'hA3. Address 8'h90 is the status attribute: bit 0 is save_state, bit 1 is the pending-update flag, and the other bits are 0.
- R9: A write to a read-only or unmapped address changes no attribute and leaves ready_n at 0.
- R10: Reads of unmapped addresses return 8'h00.
- R11: If a write is accepted in the same cycle as an update request, the write completes first. The update then stays pending and runs after the HOLD cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Asynchronous active-high reset |
| cfg_en | input | 1 | Access enable |
| wr_not_rd | input | 1 | 1 = write, 0 = read, when cfg_en is high |
| bank_sel | input | 1 | Write target: 0 = shadow copy, 1 = effective copy |
| attr_addr | input | 8 | Attribute identifier |
| wr_data | input | 8 | Write value |
| upd_req | input | 1 | Request to commit the shadow copy |
| save_state | input | 1 | Lane is in a save state |
| rd_data | output | 8 | Registered read value |
| ready_n | output | 1 | 0 = write can be accepted, 1 = busy |

## Verification
The properties assume that cfg_en, wr_not_rd, attr_addr and upd_req are driven synchronously to the configuration clock. They also assume that save_state only changes between edges. The bench meets this by changing every input on the falling edge. The properties do not assume that the driver waits for ready_n. The bench therefore presents writes during HOLD on purpose, and it raises update requests both inside and outside the save state and in the same cycle as a write.

// File: rtl/attr_bank_pkg.sv
package attr_bank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_COPY = 2'd2
    } cfg_state_e;

    // Reset value of writable attribute idx
    function automatic int attr_default(input int base, input int step, input int idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/attr_bank_ctrl.sv
module attr_bank_ctrl
    import attr_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_RW = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              wr_not_rd,
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] attr_addr,
    input  logic              upd_req,
    input  logic              save_state,
    output logic              wr_shadow,
    output logic              wr_effective,
    output logic              copy_en,
    output logic [IDX_W-1:0]  copy_idx,
    output logic              ready_n,
    output logic              upd_pending
);

    localparam logic [ADDR_W:0]  RW_LIMIT = (ADDR_W+1)'(NUM_RW);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RW - 1);

    cfg_state_e       state_q, state_d;
    logic             pend_q;
    logic [IDX_W-1:0] idx_q;
    logic             addr_ok, accepting, wr_fire, upd_go;

    assign addr_ok   = ({1'b0, attr_addr} < RW_LIMIT);
    assign accepting = (state_q == ST_IDLE);
    assign wr_fire   = cfg_en & wr_not_rd & accepting & addr_ok;
    assign upd_go    = accepting & save_state & (upd_req | pend_q) & ~wr_fire;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_fire)     state_d = ST_HOLD;
                else if (upd_go) state_d = ST_COPY;
            end
            ST_HOLD: state_d = ST_IDLE;
            ST_COPY: if (idx_q == LAST_IDX) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // pending flag and copy index
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pend_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            if (upd_go)
                pend_q <= 1'b0;
            else if (upd_req && state_q != ST_COPY)
                pend_q <= 1'b1;
            if (upd_go)
                idx_q <= '0;
            else if (state_q == ST_COPY)
                idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ready_n      = 1'b1;
        copy_en      = 1'b0;
        wr_shadow    = 1'b0;
        wr_effective = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_n      = 1'b0;
                wr_shadow    = wr_fire & ~bank_sel;
                wr_effective = wr_fire & bank_sel;
            end
            ST_HOLD: ready_n = 1'b1;
            ST_COPY: copy_en = 1'b1;
            default: ready_n = 1'b1;
        endcase
    end

    assign copy_idx    = idx_q;
    assign upd_pending = pend_q;

endmodule

// File: rtl/attr_bank_store.sv
module attr_bank_store
    import attr_bank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_RW   = 16,
    parameter int IDX_W    = 4,
    parameter int DEF_BASE = 32,
    parameter int DEF_STEP = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_shadow,
    input  logic                           wr_effective,
    input  logic [ADDR_W-1:0]              attr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           copy_en,
    input  logic [IDX_W-1:0]               copy_idx,
    output logic [NUM_RW-1:0][DATA_W-1:0]  eff_q
);

    for (genvar i = 0; i < NUM_RW; i++) begin : g_ent
        localparam logic [DATA_W-1:0] RST_VAL =
            DATA_W'(attr_default(DEF_BASE, DEF_STEP, i));

        logic [DATA_W-1:0] shd_r, eff_r;
        logic              sel;

        assign sel = (attr_addr == ADDR_W'(i));

        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                shd_r <= RST_VAL;
                eff_r <= RST_VAL;
            end else begin
                if (wr_shadow && sel)
                    shd_r <= wr_data;
                if (wr_effective && sel)
                    eff_r <= wr_data;
                else if (copy_en && copy_idx == IDX_W'(i))
                    eff_r <= shd_r;
            end
        end

        assign eff_q[i] = eff_r;
    end

endmodule

// File: rtl/attr_bank_rdmux.sv
module attr_bank_rdmux #(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int NUM_RW        = 16,
    parameter int IDX_W         = 4,
    parameter int CAP_BASE_ADDR = 128,
    parameter int NUM_CAP       = 4,
    parameter int CAP_VAL_BASE  = 160,
    parameter int STATUS_ADDR   = 144
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             attr_addr,
    input  logic [NUM_RW-1:0][DATA_W-1:0] eff_q,
    input  logic                          save_state,
    input  logic                          upd_pending,
    output logic [DATA_W-1:0]             rd_data
);

    localparam logic [ADDR_W:0]   RW_LIMIT = (ADDR_W+1)'(NUM_RW);
    localparam logic [ADDR_W:0]   CAP_LO   = (ADDR_W+1)'(CAP_BASE_ADDR);
    localparam logic [ADDR_W:0]   CAP_HI   = (ADDR_W+1)'(CAP_BASE_ADDR + NUM_CAP);
    localparam logic [ADDR_W-1:0] STAT_A   = ADDR_W'(STATUS_ADDR);

    logic [ADDR_W:0]   addr_x;
    logic [DATA_W-1:0] lookup;

    assign addr_x = {1'b0, attr_addr};

    always_comb begin
        lookup = '0;
        if (addr_x < RW_LIMIT)
            lookup = eff_q[attr_addr[IDX_W-1:0]];
        else if (addr_x >= CAP_LO && addr_x < CAP_HI)
            lookup = DATA_W'(CAP_VAL_BASE) + DATA_W'(addr_x - CAP_LO);
        else if (attr_addr == STAT_A)
            lookup = {{(DATA_W-2){1'b0}}, upd_pending, save_state};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= lookup;
    end

endmodule

// File: rtl/attr_bank_top.sv
module attr_bank_top #(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int NUM_RW        = 16,
    parameter int DEF_BASE      = 32,
    parameter int DEF_STEP      = 3,
    parameter int CAP_BASE_ADDR = 128,
    parameter int NUM_CAP       = 4,
    parameter int CAP_VAL_BASE  = 160,
    parameter int STATUS_ADDR   = 144
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              wr_not_rd,
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] attr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              upd_req,
    input  logic              save_state,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready_n
);

    localparam int IDX_W = (NUM_RW > 1) ? $clog2(NUM_RW) : 1;

    logic                          wr_shadow, wr_effective, copy_active, upd_pending;
    logic [IDX_W-1:0]              copy_idx;
    logic [NUM_RW-1:0][DATA_W-1:0] eff_q;

    attr_bank_ctrl #(
        .ADDR_W(ADDR_W), .NUM_RW(NUM_RW), .IDX_W(IDX_W)
    ) ctrl_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .wr_not_rd(wr_not_rd),
        .bank_sel(bank_sel), .attr_addr(attr_addr), .upd_req(upd_req),
        .save_state(save_state), .wr_shadow(wr_shadow),
        .wr_effective(wr_effective), .copy_en(copy_active),
        .copy_idx(copy_idx), .ready_n(ready_n), .upd_pending(upd_pending)
    );

    attr_bank_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RW(NUM_RW), .IDX_W(IDX_W),
        .DEF_BASE(DEF_BASE), .DEF_STEP(DEF_STEP)
    ) store_i (
        .clk(clk), .rst(rst), .wr_shadow(wr_shadow),
        .wr_effective(wr_effective), .attr_addr(attr_addr),
        .wr_data(wr_data), .copy_en(copy_active), .copy_idx(copy_idx),
        .eff_q(eff_q)
    );

    attr_bank_rdmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RW(NUM_RW), .IDX_W(IDX_W),
        .CAP_BASE_ADDR(CAP_BASE_ADDR), .NUM_CAP(NUM_CAP),
        .CAP_VAL_BASE(CAP_VAL_BASE), .STATUS_ADDR(STATUS_ADDR)
    ) rdmux_i (
        .clk(clk), .rst(rst), .rd_en(cfg_en & ~wr_not_rd),
        .attr_addr(attr_addr), .eff_q(eff_q), .save_state(save_state),
        .upd_pending(upd_pending), .rd_data(rd_data)
    );

endmodule

// File: rtl/attr_bank_chk.sv
module attr_bank_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NUM_RW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_en,
    input logic              wr_not_rd,
    input logic [ADDR_W-1:0] attr_addr,
    input logic              upd_req,
    input logic              save_state,
    input logic              ready_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              copy_active,
    input logic              upd_pending
);

    logic writable;
    assign writable = ({1'b0, attr_addr} < (ADDR_W+1)'(NUM_RW));

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(cfg_en && !wr_not_rd) |=> $stable(rd_data));

    assert_write_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && wr_not_rd && !ready_n && writable) |=> (ready_n && !copy_active));

    assert_hold_single_R5: assert property (@(posedge clk) disable iff (rst)
        (ready_n && !copy_active) |=> !ready_n);

    assert_copy_needs_save_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(copy_active) |-> $past(save_state));

    assert_copy_busy_R6: assert property (@(posedge clk) disable iff (rst)
        copy_active |-> ready_n);

    assert_pending_waits_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_pending && !save_state) |=> upd_pending);

    assert_ro_write_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && wr_not_rd && !ready_n && !writable &&
         !(save_state && (upd_req || upd_pending))) |=> !ready_n);

endmodule

bind attr_bank_top attr_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RW(NUM_RW)
) chk_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .wr_not_rd(wr_not_rd),
    .attr_addr(attr_addr), .upd_req(upd_req), .save_state(save_state),
    .ready_n(ready_n), .rd_data(rd_data), .copy_active(copy_active),
    .upd_pending(upd_pending)
);

// File: tb/attr_bank_top_tb_top.sv
module attr_bank_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0, wr_not_rd = 1'b0, bank_sel = 1'b0;
    logic [7:0] attr_addr = '0, wr_data = '0;
    logic       upd_req = 1'b0, save_state = 1'b0;
    logic [7:0] rd_data;
    logic       ready_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    attr_bank_top dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .wr_not_rd(wr_not_rd),
        .bank_sel(bank_sel), .attr_addr(attr_addr), .wr_data(wr_data),
        .upd_req(upd_req), .save_state(save_state), .rd_data(rd_data),
        .ready_n(ready_n)
    );

    typedef struct packed {
        logic       wr;
        logic       bank;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'h00, 8'h00, 8'h20, 4'd1},  // R1 default of attr 0
        '{1'b0, 1'b0, 8'h05, 8'h00, 8'h2F, 4'd1},  // R1 default of attr 5
        '{1'b0, 1'b0, 8'h0F, 8'h00, 8'h4D, 4'd1},  // R1 default of attr 15
        '{1'b0, 1'b0, 8'h80, 8'h00, 8'hA0, 4'd8},  // R8 capability 0
        '{1'b0, 1'b0, 8'h83, 8'h00, 8'hA3, 4'd8},  // R8 capability 3
        '{1'b0, 1'b0, 8'h40, 8'h00, 8'h00, 4'd10}, // R10 unmapped
        '{1'b1, 1'b1, 8'h03, 8'h55, 8'h55, 4'd3},  // R3 effective write
        '{1'b1, 1'b0, 8'h04, 8'h66, 8'h2C, 4'd4},  // R4 shadow write hidden
        '{1'b1, 1'b1, 8'h81, 8'hFF, 8'hA1, 4'd9},  // R9 read-only write
        '{1'b1, 1'b1, 8'h41, 8'h5A, 8'h00, 4'd9},  // R9 unmapped write
        '{1'b1, 1'b0, 8'h0E, 8'h3C, 8'h4A, 4'd4}   // R4 shadow write hidden
    };

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic b);
        cfg_en = 1'b1; wr_not_rd = 1'b1; bank_sel = b; attr_addr = a; wr_data = d;
        @(negedge clk);
        cfg_en = 1'b0; wr_not_rd = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] v);
        cfg_en = 1'b1; wr_not_rd = 1'b0; attr_addr = a;
        @(negedge clk);
        cfg_en = 1'b0;
        v = rd_data;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (ready_n && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        summary();
        $finish;
    end

    initial begin : stim
        logic [7:0] v;
        int         n;
        repeat (3) @(negedge clk);
        // R1 reset state seen while reset is high
        check(ready_n == 1'b0, "R1", {7'd0, ready_n}, 8'h00);
        check(rd_data == 8'h00, "R1", rd_data, 8'h00);
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) begin
                do_write(VEC[k].addr, VEC[k].data, VEC[k].bank);
                @(negedge clk);
            end
            do_read(VEC[k].addr, v);
            check(v == VEC[k].exp, $sformatf("R%0d", VEC[k].req), v, VEC[k].exp);
        end

        // R8 status: nothing pending, not in save state
        do_read(8'h90, v);
        check(v == 8'h00, "R8", v, 8'h00);

        // R9 read-only write keeps ready low
        do_write(8'h82, 8'h00, 1'b1);
        check(ready_n == 1'b0, "R9", {7'd0, ready_n}, 8'h00);
        do_read(8'h82, v);
        check(v == 8'hA2, "R9", v, 8'hA2);

        // R2 read data holds without an enabled read
        repeat (2) @(negedge clk);
        check(rd_data == 8'hA2, "R2", rd_data, 8'hA2);
        do_write(8'h09, 8'h13, 1'b0);
        @(negedge clk);
        check(rd_data == 8'hA2, "R2", rd_data, 8'hA2);

        // R5 one busy cycle, write during it ignored
        cfg_en = 1'b1; wr_not_rd = 1'b1; bank_sel = 1'b1; attr_addr = 8'h06; wr_data = 8'h11;
        @(negedge clk);
        check(ready_n == 1'b1, "R5", {7'd0, ready_n}, 8'h01);
        wr_data = 8'h22;
        @(negedge clk);
        cfg_en = 1'b0; wr_not_rd = 1'b0;
        check(ready_n == 1'b0, "R5", {7'd0, ready_n}, 8'h00);
        do_read(8'h06, v);
        check(v == 8'h11, "R5", v, 8'h11);

        // R6 commit in save state
        do_write(8'h00, 8'h01, 1'b0); @(negedge clk);
        do_write(8'h0F, 8'hF0, 1'b0); @(negedge clk);
        save_state = 1'b1; upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        count_busy(n);
        check(n == 16, "R6", 8'(n), 8'd16);
        do_read(8'h00, v); check(v == 8'h01, "R6", v, 8'h01);
        do_read(8'h0F, v); check(v == 8'hF0, "R6", v, 8'hF0);
        do_read(8'h04, v); check(v == 8'h66, "R6", v, 8'h66);
        do_read(8'h03, v); check(v == 8'h29, "R6", v, 8'h29);
        do_read(8'h06, v); check(v == 8'h32, "R6", v, 8'h32);

        // R7 request outside save state waits
        save_state = 1'b0;
        do_write(8'h02, 8'h77, 1'b0); @(negedge clk);
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        repeat (3) @(negedge clk);
        check(ready_n == 1'b0, "R7", {7'd0, ready_n}, 8'h00);
        do_read(8'h02, v); check(v == 8'h26, "R7", v, 8'h26);
        do_read(8'h90, v); check(v == 8'h02, "R7", v, 8'h02);
        save_state = 1'b1;
        @(negedge clk);
        count_busy(n);
        check(n == 16, "R7", 8'(n), 8'd16);
        do_read(8'h02, v); check(v == 8'h77, "R7", v, 8'h77);
        do_read(8'h90, v); check(v == 8'h01, "R8", v, 8'h01);

        // R11 write and update in the same cycle
        cfg_en = 1'b1; wr_not_rd = 1'b1; bank_sel = 1'b0; attr_addr = 8'h07; wr_data = 8'h99;
        upd_req = 1'b1;
        @(negedge clk);
        cfg_en = 1'b0; wr_not_rd = 1'b0; upd_req = 1'b0;
        check(ready_n == 1'b1, "R11", {7'd0, ready_n}, 8'h01);
        @(negedge clk);
        check(ready_n == 1'b0, "R11", {7'd0, ready_n}, 8'h00);
        @(negedge clk);
        count_busy(n);
        check(n == 16, "R11", 8'(n), 8'd16);
        do_read(8'h07, v); check(v == 8'h99, "R11", v, 8'h99);

        // R1 asynchronous reset mid-run restores defaults
        save_state = 1'b0;
        #1 rst = 1'b1;
        #2;
        check(rd_data == 8'h00, "R1", rd_data, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready_n == 1'b0, "R1", {7'd0, ready_n}, 8'h00);
        do_read(8'h00, v); check(v == 8'h20, "R1", v, 8'h20);
        do_read(8'h07, v); check(v == 8'h35, "R1", v, 8'h35);

        summary();
        $finish;
    end

endmodule